// File: doc/BRIEF.md
# Lane Digest Interleaver and Final Message Builder

This block sits behind a set of parallel hash lanes that each produced one digest over their own interleaved share of a message. On a start request it captures all lane digests at once, then streams out the second-level message that a single downstream hash pass consumes. That message takes the digests word by word across the lanes: word 0 of every lane, then word 1 of every lane, and so on. It is followed by standard Merkle-Damgard style padding: a marker byte, zero fill, and a big-endian bit-length field. The padding rounds the stream up to whole hash blocks.

The output is a word stream with a valid/ready handshake. A word is transferred on every rising clock edge where `out_vld` and `out_rdy` are both high. While `out_vld` is high and `out_rdy` is low, the word and its flags hold still. `out_vld` never drops until its word has been taken. `out_blk_end` marks the final word of every hash block. `out_final_blk` is high across all words of the last block, so the downstream core knows when to finish its pass. The lane count, digest size, word size, block size and length-field size are all parameters. With the defaults (4 lanes, 32-byte digests, 4-byte words, 64-byte blocks, 8-byte length field) the result is 128 message bytes plus padding, which is 48 words in 3 blocks.

Top module: `mh_final_builder`

## Requirements
- R1: A start is accepted only at a clock edge where `start_i` is high, every bit of `dig_vld_i` is high and no message is in progress. A start request with any lane-valid bit low has no effect and leaves `out_vld` low.
- R2: `out_vld` is low from reset until a start is accepted. It is high in the cycle right after the accepting edge.
- R3: Output word number i (counting from 0) for i < LANES*DIG_BYTES/WORD_BYTES comes from lane i mod LANES, digest word n = i div LANES. Lane k occupies `dig_i[k*DIG_BYTES*8 +: DIG_BYTES*8]`, and its word n sits at bit offset (DIG_BYTES/WORD_BYTES-1-n)*WORD_BYTES*8 inside that slice, so word 0 is the most significant.
- R4: The first word after the digest words carries 0x80 in its most significant byte and zeros elsewhere (0x80000000 for 4-byte words).
- R5: All words between the marker word and the length field are zero.
- R6: The last LEN_BYTES bytes of the stream hold the unpadded message length in bits, LANES*DIG_BYTES*8, big-endian. With the defaults this is 1024, sent as 0x00000000 then 0x00000400.
- R7: The stream uses the smallest whole number of BLK_BYTES blocks that fits the message, the marker byte and the length field (3 blocks, 48 words with the defaults). `out_blk_end` is high exactly on every (BLK_BYTES/WORD_BYTES)-th word.
- R8: `out_final_blk` is high on every word of the last block and low on all earlier words.
- R9: While `out_vld` is high and `out_rdy` is low, the next cycle keeps `out_vld` high, with `out_data`, `out_blk_end` and `out_final_blk` unchanged.
- R10: A start pulse while a message is in progress is ignored. Changes on `dig_i` after the accepting edge do not alter the stream.
- R11: `out_vld` is low in the cycle after the final word is accepted, and a new start is accepted from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to build a message from the current lane digests |
| dig_vld_i | input | LANES | Per-lane digest-valid flags |
| dig_i | input | LANES*DIG_BYTES*8 | All lane digests, lane k in slice k |
| out_vld | output | 1 | Output word valid |
| out_rdy | input | 1 | Downstream ready for a word |
| out_data | output | WORD_BYTES*8 | Output word |
| out_blk_end | output | 1 | Current word is the last of a hash block |
| out_final_blk | output | 1 | Current word belongs to the last block |

## Verification
Suppose the lane or word counters lose step. Then a word from the wrong lane or the wrong digest position appears at once on `out_data`, within the first few transfers of a message. The per-word compare against an independently computed stream catches it on that word.

Suppose the block or padding counters are off. The marker, the length words or `out_blk_end`/`out_final_blk` then land on the wrong word index, or the word count at the final flag is wrong. This shows no later than the end of the first message.

A phase that fails to return to idle shows as `out_vld` staying high past the 48th word, or as a following start being refused. Lost back-pressure state shows as a word changing while `out_rdy` is low.

// File: rtl/mh_pkg.sv
package mh_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_PAD  = 2'd2
  } mh_phase_e;

  // Smallest multiple of blk bytes holding msg bytes, one marker byte and
  // a len-byte length field.
  function automatic int padded_bytes(input int msg, input int len, input int blk);
    return ((msg + 1 + len + blk - 1) / blk) * blk;
  endfunction

endpackage

// File: rtl/mh_word_pick.sv
module mh_word_pick #(
  parameter int LANES  = 4,
  parameter int DWORDS = 8,
  parameter int WBITS  = 32,
  localparam int DBITS = DWORDS * WBITS,
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WW    = (DWORDS > 1) ? $clog2(DWORDS) : 1
) (
  input  logic [LANES*DBITS-1:0] store_i,
  input  logic [LW-1:0]          lane_i,
  input  logic [WW-1:0]          wrd_i,
  output logic [WBITS-1:0]       word_o
);

  logic [WBITS-1:0] grid [LANES][DWORDS];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar w = 0; w < DWORDS; w++) begin : g_word
      assign grid[l][w] = store_i[l*DBITS + (DWORDS-1-w)*WBITS +: WBITS];
    end
  end

  assign word_o = grid[lane_i][wrd_i];

endmodule

// File: rtl/mh_pad_word.sv
module mh_pad_word #(
  parameter int WBITS     = 32,
  parameter int PAD_WORDS = 16,
  parameter int LEN_WORDS = 2,
  parameter int MSG_BITS  = 1024,
  localparam int PW       = (PAD_WORDS > 1) ? $clog2(PAD_WORDS) : 1,
  localparam int LEN_W    = LEN_WORDS * WBITS,
  localparam int LEN_AT   = PAD_WORDS - LEN_WORDS
) (
  input  logic [PW-1:0]    pidx_i,
  output logic [WBITS-1:0] word_o
);

  localparam logic [LEN_W-1:0]  LEN_VAL = LEN_W'(MSG_BITS);
  localparam logic [WBITS-1:0]  MARK    = {8'h80, {(WBITS-8){1'b0}}};

  always_comb begin
    int k;
    k      = int'(pidx_i);
    word_o = '0;
    if (k == 0) begin
      word_o = MARK;
    end else if (k >= LEN_AT) begin
      word_o = LEN_VAL[(LEN_WORDS-1-(k-LEN_AT))*WBITS +: WBITS];
    end
  end

endmodule

// File: rtl/mh_seq.sv
module mh_seq
  import mh_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int DWORDS    = 8,
  parameter int PAD_WORDS = 16,
  parameter int BLK_WORDS = 16,
  parameter int NBLK      = 3,
  localparam int LW  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WW  = (DWORDS > 1) ? $clog2(DWORDS) : 1,
  localparam int PW  = (PAD_WORDS > 1) ? $clog2(PAD_WORDS) : 1,
  localparam int BWW = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1,
  localparam int BKW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go_i,
  input  logic      adv_i,
  output mh_phase_e phase_o,
  output logic [LW-1:0] lane_o,
  output logic [WW-1:0] wrd_o,
  output logic [PW-1:0] pidx_o,
  output logic      blk_end_o,
  output logic      final_o
);

  mh_phase_e        phase_q;
  logic [LW-1:0]    lane_q;
  logic [WW-1:0]    wrd_q;
  logic [PW-1:0]    pidx_q;
  logic [BWW-1:0]   bw_q;
  logic [BKW-1:0]   blk_q;

  logic lane_wrap, wrd_wrap, pad_done, bw_wrap;

  assign lane_wrap = (lane_q == LW'(LANES-1));
  assign wrd_wrap  = (wrd_q  == WW'(DWORDS-1));
  assign pad_done  = (pidx_q == PW'(PAD_WORDS-1));
  assign bw_wrap   = (bw_q   == BWW'(BLK_WORDS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      lane_q  <= '0;
      wrd_q   <= '0;
      pidx_q  <= '0;
      bw_q    <= '0;
      blk_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      if (go_i) begin
        phase_q <= PH_DATA;
        lane_q  <= '0;
        wrd_q   <= '0;
        pidx_q  <= '0;
        bw_q    <= '0;
        blk_q   <= '0;
      end
    end else if (adv_i) begin
      bw_q <= bw_wrap ? '0 : bw_q + 1'b1;
      if (bw_wrap) blk_q <= blk_q + 1'b1;
      if (phase_q == PH_DATA) begin
        if (lane_wrap) begin
          lane_q <= '0;
          if (wrd_wrap) phase_q <= PH_PAD;
          else          wrd_q   <= wrd_q + 1'b1;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end else begin
        if (pad_done) phase_q <= PH_IDLE;
        else          pidx_q  <= pidx_q + 1'b1;
      end
    end
  end

  assign phase_o   = phase_q;
  assign lane_o    = lane_q;
  assign wrd_o     = wrd_q;
  assign pidx_o    = pidx_q;
  assign blk_end_o = bw_wrap;
  assign final_o   = (blk_q == BKW'(NBLK-1));

endmodule

// File: rtl/mh_final_builder.sv
module mh_final_builder
  import mh_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int DIG_BYTES  = 32,
  parameter int WORD_BYTES = 4,
  parameter int BLK_BYTES  = 64,
  parameter int LEN_BYTES  = 8,
  localparam int WBITS     = WORD_BYTES * 8,
  localparam int DBITS     = DIG_BYTES * 8,
  localparam int DWORDS    = DIG_BYTES / WORD_BYTES,
  localparam int MSG_BYTES = LANES * DIG_BYTES,
  localparam int MSG_WORDS = MSG_BYTES / WORD_BYTES,
  localparam int TOT_BYTES = padded_bytes(MSG_BYTES, LEN_BYTES, BLK_BYTES),
  localparam int TOT_WORDS = TOT_BYTES / WORD_BYTES,
  localparam int PAD_WORDS = TOT_WORDS - MSG_WORDS,
  localparam int LEN_WORDS = LEN_BYTES / WORD_BYTES,
  localparam int BLK_WORDS = BLK_BYTES / WORD_BYTES,
  localparam int NBLK      = TOT_BYTES / BLK_BYTES,
  localparam int LW        = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WW        = (DWORDS > 1) ? $clog2(DWORDS) : 1,
  localparam int PW        = (PAD_WORDS > 1) ? $clog2(PAD_WORDS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [LANES-1:0]       dig_vld_i,
  input  logic [LANES*DBITS-1:0] dig_i,
  output logic                   out_vld,
  input  logic                   out_rdy,
  output logic [WBITS-1:0]       out_data,
  output logic                   out_blk_end,
  output logic                   out_final_blk
);

  mh_phase_e              phase;
  logic [LW-1:0]          lane;
  logic [WW-1:0]          wrd;
  logic [PW-1:0]          pidx;
  logic                   blk_end, final_blk, busy, go, adv;
  logic [LANES*DBITS-1:0] store_q;
  logic [WBITS-1:0]       dat_word, pad_word;

  assign busy = (phase != PH_IDLE);
  assign go   = start_i & (&dig_vld_i) & ~busy;
  assign adv  = busy & out_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  store_q <= '0;
    else if (go) store_q <= dig_i;
  end

  mh_seq #(
    .LANES(LANES), .DWORDS(DWORDS), .PAD_WORDS(PAD_WORDS),
    .BLK_WORDS(BLK_WORDS), .NBLK(NBLK)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .go_i(go), .adv_i(adv),
    .phase_o(phase), .lane_o(lane), .wrd_o(wrd), .pidx_o(pidx),
    .blk_end_o(blk_end), .final_o(final_blk)
  );

  mh_word_pick #(
    .LANES(LANES), .DWORDS(DWORDS), .WBITS(WBITS)
  ) u_pick (
    .store_i(store_q), .lane_i(lane), .wrd_i(wrd), .word_o(dat_word)
  );

  mh_pad_word #(
    .WBITS(WBITS), .PAD_WORDS(PAD_WORDS), .LEN_WORDS(LEN_WORDS),
    .MSG_BITS(MSG_BYTES * 8)
  ) u_pad (
    .pidx_i(pidx), .word_o(pad_word)
  );

  assign out_vld       = busy;
  assign out_data      = (phase == PH_DATA) ? dat_word : pad_word;
  assign out_blk_end   = busy & blk_end;
  assign out_final_blk = busy & final_blk;

endmodule

// File: rtl/mh_final_chk.sv
module mh_final_chk #(
  parameter int LANES     = 4,
  parameter int WBITS     = 32,
  parameter int TOT_WORDS = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [LANES-1:0] dig_vld_i,
  input logic             out_vld,
  input logic             out_rdy,
  input logic [WBITS-1:0] out_data,
  input logic             out_blk_end,
  input logic             out_final_blk
);

  logic [15:0] n_q;
  logic        xfer, last_x;

  assign xfer   = out_vld & out_rdy;
  assign last_x = xfer & out_blk_end & out_final_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      n_q <= '0;
    else if (last_x) n_q <= '0;
    else if (xfer)   n_q <= n_q + 1'b1;
  end

  a_r1_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld) |-> $past(start_i && (&dig_vld_i)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_data) &&
                               $stable(out_blk_end) && $stable(out_final_blk)));

  a_r8_final_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (out_final_blk && !last_x) |=> out_final_blk);

  a_r7_word_count: assert property (@(posedge clk) disable iff (!rst_n)
    last_x |-> (n_q == 16'(TOT_WORDS - 1)));

  a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n)
    last_x |=> !out_vld);

endmodule

bind mh_final_builder mh_final_chk #(
  .LANES(LANES), .WBITS(WBITS), .TOT_WORDS(TOT_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .dig_vld_i(dig_vld_i),
  .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data),
  .out_blk_end(out_blk_end), .out_final_blk(out_final_blk)
);

// File: tb/tb_mh_final_builder.sv
module tb_mh_final_builder;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int DBYTES = 32;
  localparam int WBITS  = 32;
  localparam int DWORDS = 8;
  localparam int DBITS  = DBYTES * 8;
  localparam int ALLB   = LANES * DBITS;
  localparam int MSGW   = LANES * DWORDS;   // 32
  localparam int TOTW   = 48;               // 192 bytes / 4
  localparam int BLKW   = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LANES-1:0] dig_vld = '0;
  logic [ALLB-1:0]  dig = '0;
  logic             out_vld, out_rdy = 1'b0;
  logic [WBITS-1:0] out_data;
  logic             out_blk_end, out_final_blk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mh_final_builder dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dig_vld_i(dig_vld),
    .dig_i(dig), .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data),
    .out_blk_end(out_blk_end), .out_final_blk(out_final_blk)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int i, input logic [ALLB-1:0] d);
    if (i < MSGW) return d[(i % LANES)*DBITS + (DWORDS-1-(i / LANES))*WBITS +: WBITS];
    if (i == MSGW) return 32'h8000_0000;
    if (i == TOTW-1) return 32'd1024;
    return 32'h0;
  endfunction

  function automatic logic [ALLB-1:0] rand_dig();
    logic [ALLB-1:0] r;
    for (int k = 0; k < ALLB/32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic run_msg(input logic [ALLB-1:0] d, input int rdy_pct, input bit poke);
    logic [31:0] held;
    bit hold_pend;
    int rx;
    int guard;
    string dtag;
    hold_pend = 1'b0; rx = 0; guard = 0; held = '0;
    @(negedge clk);
    dig = d; dig_vld = '1; start = 1'b1; out_rdy = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(out_vld == 1'b1, "R2 valid after start", 32'(out_vld), 32'd1);
    while (rx < TOTW && guard < 5000) begin
      out_rdy = (($urandom % 100) < rdy_pct);
      if (poke && rx == 5) begin dig = ~d; start = 1'b1; end
      else start = 1'b0;
      #1;
      if (hold_pend)
        chk(out_vld && out_data == held, "R9 hold under stall", out_data, held);
      if (out_vld && out_rdy) begin
        if (rx < MSGW) dtag = poke ? "R10 data after poke" : "R3 data order";
        else if (rx == MSGW) dtag = "R4 marker";
        else if (rx >= TOTW-2) dtag = "R6 length";
        else dtag = "R5 zero fill";
        chk(out_data == exp_word(rx, d), dtag, out_data, exp_word(rx, d));
        chk(out_blk_end == ((rx % BLKW) == BLKW-1), "R7 block end",
            32'(out_blk_end), 32'((rx % BLKW) == BLKW-1));
        chk(out_final_blk == (rx >= TOTW-BLKW), "R8 final block",
            32'(out_final_blk), 32'(rx >= TOTW-BLKW));
        rx++;
        hold_pend = 1'b0;
      end else if (out_vld) begin
        hold_pend = 1'b1;
        held = out_data;
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0; out_rdy = 1'b0;
    chk(rx == TOTW, "R7 word count", 32'(rx), 32'(TOTW));
    #1;
    chk(out_vld == 1'b0, "R11 idle after last", 32'(out_vld), 32'd0);
  endtask

  initial begin
    logic [ALLB-1:0] pat;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0, "R2 reset valid", 32'(out_vld), 32'd0);
    chk(out_blk_end == 1'b0 && out_final_blk == 1'b0, "R2 reset flags",
        32'({out_blk_end, out_final_blk}), 32'd0);
    rst_n = 1'b1;

    // R1: one lane not valid, start has no effect
    @(negedge clk);
    dig = rand_dig(); dig_vld = 4'b1011; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(out_vld == 1'b0, "R1 start gated by lane valid", 32'(out_vld), 32'd0);
      @(negedge clk);
    end

    // directed: zeros, ones, lane-tagged pattern
    run_msg('0, 100, 1'b0);
    run_msg('1, 100, 1'b0);
    for (int l = 0; l < LANES; l++)
      for (int w = 0; w < DWORDS; w++)
        pat[l*DBITS + (DWORDS-1-w)*WBITS +: WBITS] = {8'hA0 + 8'(l), 16'h0, 8'(w)};
    run_msg(pat, 60, 1'b0);
    // R11: back-to-back start right after the previous message
    run_msg(rand_dig(), 100, 1'b0);
    // random with stalls, and with a start poke while busy (R10)
    run_msg(rand_dig(), 50, 1'b0);
    run_msg(rand_dig(), 25, 1'b1);
    run_msg(rand_dig(), 80, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=%0d cycles expected=fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule